// File: doc/BRIEF.md
# Prioritized Interrupt CPU Interface

This block is the per-processor side of an interrupt controller. A distributor supplies, for every implemented interrupt, an enable bit, a pending bit and an 8-bit priority for this processor. It also supplies the line level, the trigger configuration (edge or level), the handling model (all processors or only this one) and whether the interrupt targets this processor. The block sweeps this state every cycle and finds the most urgent interrupt. It raises one request line towards the processor when that interrupt is allowed to preempt the handler that is running now.

Software uses a small register window. Reading the acknowledge register claims the winning interrupt. The block then asks the distributor, with a one-cycle pulse, to clear that pending bit, and it makes the interrupt the running one. Writing an ID to the end-of-interrupt register completes that interrupt. Each interrupt stores the ID that was running when it was claimed, so completions unwind the nesting in the correct order. A completion may also name an interrupt that is preempted rather than running; that entry is then cut out of the chain. A level-triggered line that is still high at completion is handed back to the distributor to be set pending again.

Register accesses are single-cycle strobes. Read data is registered and appears after the clock edge that takes the read. The clear and re-pend request pulses are valid during the access cycle itself.

Top module: `cpuif_top`

## Requirements
- R1: After reset the request line is low. Reads return: control 0, priority mask 0, running priority 0x100, highest pending 1023, acknowledge 1023.
- R2: Only interrupts that are both enabled and pending compete. The lowest priority value wins, and equal priorities resolve to the lowest ID. The winner is read at offset 0x18.
- R3: The winner is reported as highest pending only when its priority is strictly below the priority mask (offset 0x04, bits 7:0). Otherwise offset 0x18 reads 1023.
- R4: The request line is high exactly when a highest pending interrupt is reported and its priority is strictly below the running priority (offset 0x14).
- R5: When the distributor enable input or the interface enable (offset 0x00, bit 0) is low, the request line is low and highest pending reads 1023.
- R6: A read of offset 0x0C returns 1023 and changes nothing when no interrupt is reported or the reported one does not preempt the running priority. In that case no clear pulse is issued.
- R7: A successful read of offset 0x0C does four things:
  - it returns the winner's ID;
  - it pulses the pending-clear request with that ID, with the all-processor flag equal to the interrupt's model input;
  - it makes the interrupt the running one;
  - it sets the running priority to that interrupt's priority.
- R8: Writing the running ID to offset 0x10 (bits 9:0) restores the interrupt that was running when it was claimed, together with that interrupt's current priority. If nothing was running at claim time, the running priority becomes 0x100.
- R9: Writing the ID of a preempted interrupt to offset 0x10 leaves the running interrupt unchanged. It removes the preempted interrupt from the chain, so a later completion skips past it.
- R10: An end-of-interrupt write is ignored when the ID is at or above the implemented count, or when nothing is running. An ignored write issues no re-pend pulse.
- R11: An accepted end-of-interrupt pulses the re-pend request with the completed ID only if all four of these hold for that interrupt:
  - it is level-triggered (edge input 0);
  - it is enabled;
  - its line is still high;
  - it targets this processor.
- R12: Control keeps only bit 0 and the mask keeps only bits 7:0. Offsets other than 0x00, 0x04, 0x0C, 0x14 and 0x18 read zero. Writes to any offset other than 0x00, 0x04 and 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dist_en | input | 1 | Global distributor enable |
| irq_enable | input | NUM_IRQ | Per-interrupt enable for this processor |
| irq_pending | input | NUM_IRQ | Per-interrupt pending for this processor |
| irq_prio | input | NUM_IRQ*PRIO_W | Per-interrupt priority, ID i at bits i*PRIO_W upward |
| irq_line | input | NUM_IRQ | Current level of each interrupt input |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_allcpu | input | NUM_IRQ | Model bit: clear pending for all processors on claim |
| irq_to_me | input | NUM_IRQ | Interrupt targets this processor |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| pend_clr_o | output | 1 | Request to clear a pending bit (access cycle) |
| pend_clr_id_o | output | 10 | ID to clear |
| pend_clr_all_o | output | 1 | Clear for all processors |
| repend_o | output | 1 | Request to set a level interrupt pending again |
| repend_id_o | output | 10 | ID to set pending again |

## Verification
The bench claims three interrupts in a nest and then completes the middle one first. A design that only kept a stack would then fall back to the wrong priority, 0x10 instead of 0x20. Ties are placed at equal priority on two IDs, so a design comparing with less-or-equal would report the higher ID. It sets the mask equal to the winner's priority and expects nothing to be reported. A claim while an equal-priority handler runs must return 1023 without a clear pulse. End-of-interrupt writes with an unimplemented ID, with nothing running, to an edge interrupt and to an untargeted interrupt must all produce no re-pend. A design that tested fewer of those conditions would re-pend in error.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int          ID_W      = 10;
  localparam int          PRIO_W    = 8;
  localparam int          RPRIO_W   = PRIO_W + 1;
  localparam logic [ID_W-1:0]    NO_IRQ    = 10'd1023;
  localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_PMASK = 8'h04;
  localparam logic [7:0] OFS_CLAIM = 8'h0C;
  localparam logic [7:0] OFS_DONE  = 8'h10;
  localparam logic [7:0] OFS_RPRIO = 8'h14;
  localparam logic [7:0] OFS_HPEND = 8'h18;

  // strict urgency compare on widened priorities
  function automatic logic more_urgent(input logic [RPRIO_W-1:0] a,
                                       input logic [RPRIO_W-1:0] b);
    return a < b;
  endfunction

  function automatic logic [RPRIO_W-1:0] widen(input logic [PRIO_W-1:0] p);
    return {1'b0, p};
  endfunction
endpackage

// File: rtl/cpuif_arbiter.sv
module cpuif_arbiter
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      dist_en,
  input  logic                      cpu_en,
  input  logic [NUM_IRQ-1:0]        en,
  input  logic [NUM_IRQ-1:0]        pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         pmask,
  input  logic [RPRIO_W-1:0]        run_prio,
  output logic [ID_W-1:0]           hp_id,
  output logic [RPRIO_W-1:0]        hp_prio,
  output logic                      req
);
  logic [ID_W-1:0]    best_id;
  logic [RPRIO_W-1:0] best_prio;

  // upward sweep, strict compare: ties keep the lower ID
  always_comb begin
    best_id   = NO_IRQ;
    best_prio = IDLE_PRIO;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (en[i] && pend[i] &&
          more_urgent(widen(prio[i*PRIO_W +: PRIO_W]), best_prio)) begin
        best_id   = ID_W'(i);
        best_prio = widen(prio[i*PRIO_W +: PRIO_W]);
      end
    end
  end

  always_comb begin
    hp_id   = NO_IRQ;
    hp_prio = IDLE_PRIO;
    if (dist_en && cpu_en && more_urgent(best_prio, widen(pmask))) begin
      hp_id   = best_id;
      hp_prio = best_prio;
    end
  end

  assign req = (hp_id != NO_IRQ) && more_urgent(hp_prio, run_prio);
endmodule

// File: rtl/cpuif_chain.sv
module cpuif_chain
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic [ID_W-1:0]  run_id,
  input  logic             pop,
  input  logic             splice,
  input  logic [ID_W-1:0]  cut_id,
  output logic [ID_W-1:0]  pred_run
);
  logic [ID_W-1:0]    pred [NUM_IRQ];
  logic [NUM_IRQ-1:0] active;
  logic [IDX_W-1:0]   run_idx;
  logic [IDX_W-1:0]   cut_idx;

  assign run_idx  = run_id[IDX_W-1:0];
  assign cut_idx  = cut_id[IDX_W-1:0];
  assign pred_run = (run_id == NO_IRQ) ? NO_IRQ : pred[run_idx];

  // active marks chain members, so the splice is a parallel match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_IRQ; j++) pred[j] <= NO_IRQ;
      active <= '0;
    end else begin
      if (push) begin
        pred[push_idx]   <= run_id;
        active[push_idx] <= 1'b1;
      end
      if (pop) active[run_idx] <= 1'b0;
      if (splice) begin
        for (int j = 0; j < NUM_IRQ; j++)
          if (active[j] && pred[j] == cut_id) pred[j] <= pred[cut_idx];
        active[cut_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpuif_top.sv
module cpuif_top
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dist_en,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [NUM_IRQ-1:0]        irq_pending,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [NUM_IRQ-1:0]        irq_line,
  input  logic [NUM_IRQ-1:0]        irq_edge,
  input  logic [NUM_IRQ-1:0]        irq_allcpu,
  input  logic [NUM_IRQ-1:0]        irq_to_me,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic [7:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      irq_o,
  output logic                      pend_clr_o,
  output logic [ID_W-1:0]           pend_clr_id_o,
  output logic                      pend_clr_all_o,
  output logic                      repend_o,
  output logic [ID_W-1:0]           repend_id_o
);
  localparam int              IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W:0]   NUM_V = (ID_W+1)'(NUM_IRQ);

  logic                cpu_en;
  logic [PRIO_W-1:0]   pmask;
  logic [ID_W-1:0]     run_id;
  logic [RPRIO_W-1:0]  run_prio;
  logic [ID_W-1:0]     hp_id;
  logic [RPRIO_W-1:0]  hp_prio;
  logic [ID_W-1:0]     pred_run;
  logic [ID_W-1:0]     eoi_id;
  logic [IDX_W-1:0]    eoi_idx;
  logic [IDX_W-1:0]    hp_idx;
  logic                claim_rd, ack_ok, eoi_ok, eoi_pop, eoi_splice;
  logic                unused_wdata;

  function automatic logic [RPRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
    if (id == NO_IRQ) return IDLE_PRIO;
    return widen(irq_prio[int'(id[IDX_W-1:0])*PRIO_W +: PRIO_W]);
  endfunction

  cpuif_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .dist_en  (dist_en),
    .cpu_en   (cpu_en),
    .en       (irq_enable),
    .pend     (irq_pending),
    .prio     (irq_prio),
    .pmask    (pmask),
    .run_prio (run_prio),
    .hp_id    (hp_id),
    .hp_prio  (hp_prio),
    .req      (irq_o)
  );

  assign hp_idx   = hp_id[IDX_W-1:0];
  assign eoi_id   = reg_wdata[ID_W-1:0];
  assign eoi_idx  = eoi_id[IDX_W-1:0];
  assign unused_wdata = ^reg_wdata;

  assign claim_rd   = reg_rd && (reg_addr == OFS_CLAIM);
  assign ack_ok     = claim_rd && (hp_id != NO_IRQ) && more_urgent(hp_prio, run_prio);
  assign eoi_ok     = reg_wr && (reg_addr == OFS_DONE) &&
                      ({1'b0, eoi_id} < NUM_V) && (run_id != NO_IRQ);
  assign eoi_pop    = eoi_ok && (eoi_id == run_id);
  assign eoi_splice = eoi_ok && (eoi_id != run_id);

  cpuif_chain #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_ok),
    .push_idx (hp_idx),
    .run_id   (run_id),
    .pop      (eoi_pop),
    .splice   (eoi_splice),
    .cut_id   (eoi_id),
    .pred_run (pred_run)
  );

  assign pend_clr_o     = ack_ok;
  assign pend_clr_id_o  = hp_id;
  assign pend_clr_all_o = ack_ok && irq_allcpu[hp_idx];

  assign repend_o    = eoi_ok && !irq_edge[eoi_idx] && irq_enable[eoi_idx] &&
                       irq_line[eoi_idx] && irq_to_me[eoi_idx];
  assign repend_id_o = eoi_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en   <= 1'b0;
      pmask    <= '0;
      run_id   <= NO_IRQ;
      run_prio <= IDLE_PRIO;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL)  cpu_en <= reg_wdata[0];
      if (reg_wr && reg_addr == OFS_PMASK) pmask  <= reg_wdata[PRIO_W-1:0];
      if (ack_ok) begin
        run_id   <= hp_id;
        run_prio <= hp_prio;
      end else if (eoi_pop) begin
        run_id   <= pred_run;
        run_prio <= prio_of(pred_run);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL:  reg_rdata <= 32'(cpu_en);
        OFS_PMASK: reg_rdata <= 32'(pmask);
        OFS_CLAIM: reg_rdata <= ack_ok ? 32'(hp_id) : 32'(NO_IRQ);
        OFS_RPRIO: reg_rdata <= 32'(run_prio);
        OFS_HPEND: reg_rdata <= 32'(hp_id);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cpuif_checker.sv
module cpuif_checker
  import cpuif_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               dist_en,
  input logic               cpu_en,
  input logic               irq_o,
  input logic [ID_W-1:0]    run_id,
  input logic [RPRIO_W-1:0] run_prio,
  input logic [ID_W-1:0]    hp_id,
  input logic [RPRIO_W-1:0] hp_prio,
  input logic [PRIO_W-1:0]  pmask,
  input logic               ack_ok,
  input logic               pend_clr_o,
  input logic               reg_rd,
  input logic [7:0]         reg_addr,
  input logic               repend_o
);
  AST_REQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (dist_en && cpu_en)); // R5
  AST_REQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (hp_id != NO_IRQ && hp_prio < run_prio)); // R4
  AST_HP_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_id != NO_IRQ) |-> (hp_prio < {1'b0, pmask})); // R3
  AST_IDLE_RUN_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO)); // R8
  AST_CLAIM_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> (run_prio < $past(run_prio))); // R7
  AST_CLR_ONLY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_o |-> (reg_rd && reg_addr == OFS_CLAIM)); // R6
  AST_REPEND_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    repend_o |-> (run_id != NO_IRQ)); // R10
endmodule

bind cpuif_top cpuif_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dist_en  (dist_en),
  .cpu_en   (cpu_en),
  .irq_o    (irq_o),
  .run_id   (run_id),
  .run_prio (run_prio),
  .hp_id    (hp_id),
  .hp_prio  (hp_prio),
  .pmask    (pmask),
  .ack_ok   (ack_ok),
  .pend_clr_o (pend_clr_o),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .repend_o (repend_o)
);

// File: tb/tb_cpuif_top.sv
`timescale 1ns/1ps
module tb_cpuif_top;
  localparam int N = 32;
  localparam int NONE = 1023;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          dist_en = 0;
  logic [N-1:0]  en = '0, pend = '0, line = '0, edge_cfg = '0, allcpu = '0, to_me = '0;
  logic [N*8-1:0] prio = '1;
  logic          reg_rd = 0, reg_wr = 0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_o, pend_clr_o, pend_clr_all_o, repend_o;
  logic [9:0]    pend_clr_id_o, repend_id_o;

  int vectors = 0, miscompares = 0;
  logic       s_clr, s_all, s_rep;
  logic [9:0] s_clr_id, s_rep_id;
  logic [31:0] d;

  always #4 clk = ~clk;

  cpuif_top #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en),
    .irq_enable(en), .irq_pending(pend), .irq_prio(prio),
    .irq_line(line), .irq_edge(edge_cfg), .irq_allcpu(allcpu), .irq_to_me(to_me),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o),
    .pend_clr_o(pend_clr_o), .pend_clr_id_o(pend_clr_id_o), .pend_clr_all_o(pend_clr_all_o),
    .repend_o(repend_o), .repend_id_o(repend_id_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] dat);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 s_clr = pend_clr_o; s_clr_id = pend_clr_id_o; s_all = pend_clr_all_o;
    @(posedge clk); #1 reg_rd = 0;
    dat = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1;
    #1 s_rep = repend_o; s_rep_id = repend_id_o;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic setp(input int id, input logic [7:0] p);
    prio[id*8 +: 8] = p;
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq_o), 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 pmask", d, 0);
    rd(8'h14, d); chk("R1 rprio", d, 32'h100);
    rd(8'h18, d); chk("R1 hpend", d, NONE);
    rd(8'h0C, d); chk("R1 claim", d, NONE);
  endtask

  task automatic t_arbitrate;
    setp(1, 8'h00); setp(2, 8'h00); setp(3, 8'h40); setp(4, 8'h08);
    setp(5, 8'h10); setp(7, 8'h20); setp(9, 8'h20);
    en[2] = 1; en[3] = 1; en[4] = 1; en[5] = 1; en[7] = 1; en[9] = 1;
    pend[1] = 1; pend[3] = 1; pend[7] = 1; pend[9] = 1;
    allcpu[7] = 1;
    dist_en = 1;
    wr(8'h00, 1); wr(8'h04, 32'hFF);
    rd(8'h18, d); chk("R2 tie lowest id", d, 7);
    #1 chk("R4 irq raised", 32'(irq_o), 1);
  endtask

  task automatic t_mask;
    wr(8'h04, 32'h20);
    rd(8'h18, d); chk("R3 equal mask hides", d, NONE);
    chk("R4 irq low masked", 32'(irq_o), 0);
    wr(8'h04, 32'h21);
    rd(8'h18, d); chk("R3 below mask shown", d, 7);
    wr(8'h04, 32'hFF);
  endtask

  task automatic t_enables;
    wr(8'h00, 0);
    rd(8'h18, d); chk("R5 cpu off hpend", d, NONE);
    chk("R5 cpu off irq", 32'(irq_o), 0);
    wr(8'h00, 1);
    @(negedge clk); dist_en = 0; #1;
    chk("R5 dist off irq", 32'(irq_o), 0);
    rd(8'h18, d); chk("R5 dist off hpend", d, NONE);
    dist_en = 1;
  endtask

  task automatic t_claim;
    rd(8'h0C, d); chk("R7 claim id", d, 7);
    chk("R7 clr pulse", {s_clr, s_all, 20'd0, s_clr_id}, {1'b1, 1'b1, 20'd0, 10'd7});
    pend[7] = 0;
    rd(8'h14, d); chk("R7 rprio", d, 32'h20);
    rd(8'h18, d); chk("R2 next winner", d, 9);
    chk("R4 equal prio no irq", 32'(irq_o), 0);
    rd(8'h0C, d); chk("R6 no preempt claim", d, NONE);
    chk("R6 no clr pulse", 32'(s_clr), 0);
    rd(8'h14, d); chk("R6 rprio kept", d, 32'h20);
  endtask

  task automatic t_nest;
    @(negedge clk); pend[5] = 1; #1;
    chk("R4 preempt irq", 32'(irq_o), 1);
    rd(8'h0C, d); chk("R7 claim 5", d, 5);
    chk("R7 local clear", {s_clr, s_all}, 2'b10);
    pend[5] = 0;
    @(negedge clk); pend[4] = 1;
    rd(8'h0C, d); chk("R7 claim 4", d, 4);
    pend[4] = 0;
    rd(8'h14, d); chk("R7 rprio 4", d, 32'h08);
    wr(8'h10, 5);
    rd(8'h14, d); chk("R9 splice keeps run", d, 32'h08);
    wr(8'h10, 4);
    rd(8'h14, d); chk("R9 skip spliced", d, 32'h20);
    wr(8'h10, 7);
    rd(8'h14, d); chk("R8 back to idle", d, 32'h100);
    chk("R4 irq after unwind", 32'(irq_o), 1);
  endtask

  task automatic t_eoi_rules;
    line[9] = 1; to_me[9] = 1;
    wr(8'h10, 9); chk("R10 nothing running", 32'(s_rep), 0);
    rd(8'h14, d); chk("R10 rprio idle", d, 32'h100);
    rd(8'h0C, d); chk("R7 claim 9", d, 9);
    pend[9] = 0;
    wr(8'h10, 40); chk("R10 id out of range", 32'(s_rep), 0);
    rd(8'h14, d); chk("R10 rprio kept", d, 32'h20);
    wr(8'h10, NONE); chk("R10 spurious id", 32'(s_rep), 0);
    wr(8'h10, 9); chk("R11 level repend", {22'd0, s_rep, s_rep_id}, {22'd0, 1'b1, 10'd9});
    rd(8'h14, d); chk("R8 idle after 9", d, 32'h100);
    rd(8'h0C, d); chk("R7 claim 3", d, 3);
    pend[3] = 0; line[3] = 1; to_me[3] = 0;
    wr(8'h10, 3); chk("R11 untargeted", 32'(s_rep), 0);
    @(negedge clk); pend[3] = 1;
    rd(8'h0C, d); chk("R7 claim 3 again", d, 3);
    pend[3] = 0; to_me[3] = 1; edge_cfg[3] = 1;
    wr(8'h10, 3); chk("R11 edge no repend", 32'(s_rep), 0);
  endtask

  task automatic t_decode;
    wr(8'h14, 32'h55);
    rd(8'h14, d); chk("R12 rprio read only", d, 32'h100);
    wr(8'h08, 32'hFF);
    rd(8'h08, d); chk("R12 unused reads 0", d, 0);
    rd(8'h20, d); chk("R12 other offset 0", d, 0);
    wr(8'h04, 32'h1AB);
    rd(8'h04, d); chk("R12 mask 8 bits", d, 32'hAB);
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, d); chk("R12 ctrl bit0", d, 0);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_arbitrate();
    t_mask();
    t_enables();
    t_claim();
    t_nest();
    t_eoi_rules();
    t_decode();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule